// File: doc/BRIEF.md
# Processor Status Register Pair

This block keeps a processor's two 8-bit status words. The high word holds the external sense input, the flag that drives an output pin, the interrupt-inhibit bit and a 3-bit stack pointer. The low word holds the 2-bit condition code, the carry, inter-digit carry and overflow bits, the register bank select, the with-carry control and the compare-mode control. A command port accepts one operation per accepted transfer. The operation can copy the accumulator into a word, copy a word back out, clear or set the bits chosen by a mask, or test the masked bits and report the result in the condition code.

Commands arrive on a valid/ready port. Read-back values leave on a valid/ready response port that holds one entry. `cmd_ready` is high when the response slot is empty or is being drained in the same cycle (`cmd_ready = !rsp_valid || rsp_ready`). A held response keeps its data until it is taken. The arithmetic unit updates the low word through plain pins. The sense and flag pins are plain wires to the outside.

Top module: `psw_pair`

## Requirements
- R1: While `rst_n` is low, and at the first check after it is released, the stored high and low bits are all zero, `flag_pin` is 0 and `rsp_valid` is 0.
- R2: An accepted LOAD_HI (`cmd_op`=1) copies `cmd_acc` bits 6, 5 and 2..0 into the high word. `stat_hi` bits 4 and 3 always read 0. Bit 6 is the flag, bit 5 is interrupt inhibit and bits 2..0 are the stack pointer.
- R3: An accepted LOAD_LO (`cmd_op`=2) copies all 8 bits of `cmd_acc` into the low word. In the low word, bits 7..6 are the condition code, bit 5 is inter-digit carry, bit 4 is bank select, bit 3 is with-carry, bit 2 is overflow, bit 1 is compare mode and bit 0 is carry.
- R4: An accepted STORE_HI (`cmd_op`=3) or STORE_LO (`cmd_op`=4) presents the word's image on `rsp_acc`, with `rsp_valid` high, from the next cycle on. The image is taken at the cycle of acceptance.
- R5: An accepted CLEAR_HI (5) or CLEAR_LO (6) writes the word AND NOT `cmd_mask`.
- R6: An accepted SET_HI (7) or SET_LO (8) writes the word OR `cmd_mask`.
- R7: An accepted TEST_HI (9) or TEST_LO (10) changes only low bits 7..6. They become 00 when every bit selected by `cmd_mask` is 1 in the tested word, and 10 otherwise. An empty mask gives 00.
- R8: `stat_hi` bit 7 always equals the live `sense_pin`. Writes to that bit have no effect.
- R9: `flag_pin` always equals `stat_hi` bit 6.
- R10: With `alu_we` high, low bits 7..6, 5, 2 and 0 take `alu_cc`, `alu_idc`, `alu_ovf` and `alu_cy`. An accepted LOAD_LO, CLEAR_LO, SET_LO, TEST_HI or TEST_LO in the same cycle takes precedence and the ALU update is dropped.
- R11: `cmd_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_acc` is held.
- R12: A cycle with no accepted command and no `alu_we` leaves both words unchanged. This includes NOP (0), undefined codes 11..15 and commands that are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 4 | Operation code |
| cmd_mask | input | 8 | Bit mask for clear, set and test |
| cmd_acc | input | 8 | Accumulator value for loads |
| rsp_valid | output | 1 | Read-back value present |
| rsp_ready | input | 1 | Consumer takes the read-back value |
| rsp_acc | output | 8 | Read-back value for the accumulator |
| sense_pin | input | 1 | External sense input |
| flag_pin | output | 1 | External flag output |
| alu_we | input | 1 | ALU flag update strobe |
| alu_cc | input | 2 | New condition code |
| alu_idc | input | 1 | New inter-digit carry |
| alu_ovf | input | 1 | New overflow |
| alu_cy | input | 1 | New carry |
| stat_hi | output | 8 | High word image |
| stat_lo | output | 8 | Low word image |

## Verification
The checker watches these on every cycle: the sense and flag pin mirroring, the always-zero high bits 4 and 3, the ready rule and the holding of a stalled response, the exact effect of a low-word load, and the fact that a test or an idle cycle touches nothing outside the condition code. The bench's scenarios are needed for the rest: the arithmetic of masked clear, set and test on both words, the 00/10 test results including the empty mask, and the ALU update losing to a low-word command in the same cycle. A reference model covers these across long random mixes of operations, stalls and pin changes.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int STAT_W    = 8;
  localparam int CC_W      = 2;
  localparam int OP_W      = 4;
  localparam int SP_W      = 3;
  localparam int NBANK     = 2;
  localparam int BANK_HI   = 0;
  localparam int BANK_LO   = 1;

  localparam int HI_SENSE  = 7;
  localparam int HI_FLAG   = 6;
  localparam int HI_INH    = 5;
  localparam int HI_SP_LSB = 0;

  localparam int LO_CC_LSB = 6;
  localparam int LO_IDC    = 5;
  localparam int LO_BANK   = 4;
  localparam int LO_WC     = 3;
  localparam int LO_OVF    = 2;
  localparam int LO_COM    = 1;
  localparam int LO_CY     = 0;

  localparam logic [STAT_W-1:0] HI_KEEP =
    STAT_W'((1 << HI_FLAG) | (1 << HI_INH) | (((1 << SP_W) - 1) << HI_SP_LSB));
  localparam logic [STAT_W-1:0] LO_KEEP = '1;

  localparam logic [CC_W-1:0] CC_ALL_SET  = 2'b00;
  localparam logic [CC_W-1:0] CC_SOME_CLR = 2'b10;

  typedef enum logic [OP_W-1:0] {
    OP_NOP      = 4'd0,
    OP_LOAD_HI  = 4'd1,
    OP_LOAD_LO  = 4'd2,
    OP_STORE_HI = 4'd3,
    OP_STORE_LO = 4'd4,
    OP_CLR_HI   = 4'd5,
    OP_CLR_LO   = 4'd6,
    OP_SET_HI   = 4'd7,
    OP_SET_LO   = 4'd8,
    OP_TEST_HI  = 4'd9,
    OP_TEST_LO  = 4'd10
  } psw_op_e;

  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_STORE, K_CLEAR, K_SET, K_TEST
  } psw_kind_e;

  typedef struct packed {
    psw_kind_e kind;
    logic      bank;
  } psw_cmd_t;
endpackage

// File: rtl/psw_op_decode.sv
module psw_op_decode
  import psw_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output psw_cmd_t        cmd_o
);
  always_comb begin
    cmd_o.kind = K_NONE;
    cmd_o.bank = 1'b0;
    case (op_i)
      OP_LOAD_HI:  begin cmd_o.kind = K_LOAD;  cmd_o.bank = 1'b0; end
      OP_LOAD_LO:  begin cmd_o.kind = K_LOAD;  cmd_o.bank = 1'b1; end
      OP_STORE_HI: begin cmd_o.kind = K_STORE; cmd_o.bank = 1'b0; end
      OP_STORE_LO: begin cmd_o.kind = K_STORE; cmd_o.bank = 1'b1; end
      OP_CLR_HI:   begin cmd_o.kind = K_CLEAR; cmd_o.bank = 1'b0; end
      OP_CLR_LO:   begin cmd_o.kind = K_CLEAR; cmd_o.bank = 1'b1; end
      OP_SET_HI:   begin cmd_o.kind = K_SET;   cmd_o.bank = 1'b0; end
      OP_SET_LO:   begin cmd_o.kind = K_SET;   cmd_o.bank = 1'b1; end
      OP_TEST_HI:  begin cmd_o.kind = K_TEST;  cmd_o.bank = 1'b0; end
      OP_TEST_LO:  begin cmd_o.kind = K_TEST;  cmd_o.bank = 1'b1; end
      default:     begin cmd_o.kind = K_NONE;  cmd_o.bank = 1'b0; end
    endcase
  end
endmodule

// File: rtl/psw_mask_alu.sv
module psw_mask_alu
  import psw_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  psw_kind_e    kind_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] nxt_o,
  output logic         all_set_o
);
  always_comb begin
    case (kind_i)
      K_LOAD:  nxt_o = acc_i;
      K_CLEAR: nxt_o = cur_i & ~mask_i;
      K_SET:   nxt_o = cur_i | mask_i;
      default: nxt_o = cur_i;
    endcase
  end

  assign all_set_o = ((cur_i & mask_i) == mask_i);
endmodule

// File: rtl/psw_bank_reg.sv
module psw_bank_reg #(
  parameter int           W    = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    store_q <= '0;
    else if (we_i) store_q <= d_i & KEEP;
  end

  assign q_o = store_q & KEEP;
endmodule

// File: rtl/psw_rsp_slot.sv
module psw_rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/psw_pair.sv
module psw_pair
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [STAT_W-1:0] cmd_mask,
  input  logic [STAT_W-1:0] cmd_acc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [STAT_W-1:0] rsp_acc,
  input  logic              sense_pin,
  output logic              flag_pin,
  input  logic              alu_we,
  input  logic [CC_W-1:0]   alu_cc,
  input  logic              alu_idc,
  input  logic              alu_ovf,
  input  logic              alu_cy,
  output logic [STAT_W-1:0] stat_hi,
  output logic [STAT_W-1:0] stat_lo
);
  psw_cmd_t          dec;
  psw_kind_e         kind_eff;
  logic              accept;
  logic [STAT_W-1:0] bank_q   [NBANK];
  logic [STAT_W-1:0] bank_img [NBANK];
  logic [STAT_W-1:0] bank_nxt [NBANK];
  logic [STAT_W-1:0] bank_d   [NBANK];
  logic              bank_we  [NBANK];
  logic              bank_all [NBANK];
  logic [CC_W-1:0]   test_cc;
  logic              is_write;

  psw_op_decode u_dec (.op_i(cmd_op), .cmd_o(dec));

  assign accept   = cmd_valid && cmd_ready;
  assign kind_eff = accept ? dec.kind : K_NONE;
  assign is_write = (kind_eff == K_LOAD) || (kind_eff == K_CLEAR) || (kind_eff == K_SET);

  always_comb begin
    bank_img[BANK_HI]           = bank_q[BANK_HI];
    bank_img[BANK_HI][HI_SENSE] = sense_pin;
    bank_img[BANK_LO]           = bank_q[BANK_LO];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    psw_kind_e bank_kind;
    assign bank_kind = (int'(dec.bank) == b) ? kind_eff : K_NONE;

    psw_mask_alu #(.W(STAT_W)) u_alu (
      .kind_i   (bank_kind),
      .cur_i    (bank_img[b]),
      .mask_i   (cmd_mask),
      .acc_i    (cmd_acc),
      .nxt_o    (bank_nxt[b]),
      .all_set_o(bank_all[b])
    );

    psw_bank_reg #(
      .W   (STAT_W),
      .KEEP(b == BANK_HI ? HI_KEEP : LO_KEEP)
    ) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we_i (bank_we[b]),
      .d_i  (bank_d[b]),
      .q_o  (bank_q[b])
    );
  end

  assign test_cc = bank_all[dec.bank] ? CC_ALL_SET : CC_SOME_CLR;

  always_comb begin
    bank_we[BANK_HI] = is_write && (dec.bank == 1'b0);
    bank_d[BANK_HI]  = bank_nxt[BANK_HI];
  end

  always_comb begin
    bank_we[BANK_LO] = 1'b0;
    bank_d[BANK_LO]  = bank_q[BANK_LO];
    if (is_write && dec.bank == 1'b1) begin
      bank_we[BANK_LO] = 1'b1;
      bank_d[BANK_LO]  = bank_nxt[BANK_LO];
    end else if (kind_eff == K_TEST) begin
      bank_we[BANK_LO] = 1'b1;
      bank_d[BANK_LO][LO_CC_LSB +: CC_W] = test_cc;
    end else if (alu_we) begin
      bank_we[BANK_LO] = 1'b1;
      bank_d[BANK_LO][LO_CC_LSB +: CC_W] = alu_cc;
      bank_d[BANK_LO][LO_IDC] = alu_idc;
      bank_d[BANK_LO][LO_OVF] = alu_ovf;
      bank_d[BANK_LO][LO_CY]  = alu_cy;
    end
  end

  psw_rsp_slot #(.W(STAT_W)) u_rsp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (kind_eff == K_STORE),
    .data_i (bank_img[dec.bank]),
    .ready_i(rsp_ready),
    .valid_o(rsp_valid),
    .data_o (rsp_acc),
    .free_o (cmd_ready)
  );

  assign stat_hi  = bank_img[BANK_HI];
  assign stat_lo  = bank_img[BANK_LO];
  assign flag_pin = bank_q[BANK_HI][HI_FLAG];
endmodule

// File: rtl/psw_pair_chk.sv
module psw_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [3:0] cmd_op,
  input logic [7:0] cmd_acc,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_acc,
  input logic       sense_pin,
  input logic       flag_pin,
  input logic       alu_we,
  input logic [7:0] stat_hi,
  input logic [7:0] stat_lo
);
  logic acc_c;
  assign acc_c = cmd_valid && cmd_ready;

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_acc));

  a_r11_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready);

  a_r4_store_responds: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c && (cmd_op == 4'd3 || cmd_op == 4'd4) |=> rsp_valid);

  a_r3_load_lo_exact: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c && cmd_op == 4'd2 |=> stat_lo == $past(cmd_acc));

  a_r7_test_only_cc: assert property (@(posedge clk) disable iff (!rst_n)
    acc_c && (cmd_op == 4'd9 || cmd_op == 4'd10)
    |=> stat_lo[5:0] == $past(stat_lo[5:0]) && stat_hi[6:0] == $past(stat_hi[6:0]));

  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_c && !alu_we |=> $stable(stat_lo) && stat_hi[6:0] == $past(stat_hi[6:0]));

  a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hi[4:3] == 2'b00);

  a_r8_sense_live: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hi[7] == sense_pin);

  a_r9_flag_pin: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pin == stat_hi[6]);
endmodule

bind psw_pair psw_pair_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .cmd_acc  (cmd_acc),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_acc  (rsp_acc),
  .sense_pin(sense_pin),
  .flag_pin (flag_pin),
  .alu_we   (alu_we),
  .stat_hi  (stat_hi),
  .stat_lo  (stat_lo)
);

// File: tb/psw_pair_bench.sv
module psw_pair_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] HK = 8'h67;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_mask = '0;
  logic [7:0] cmd_acc = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_acc;
  logic       sense_pin = 1'b0;
  logic       flag_pin;
  logic       alu_we = 1'b0;
  logic [1:0] alu_cc = '0;
  logic       alu_idc = 1'b0;
  logic       alu_ovf = 1'b0;
  logic       alu_cy = 1'b0;
  logic [7:0] stat_hi;
  logic [7:0] stat_lo;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_hi = '0;
  logic [7:0] m_lo = '0;
  logic       m_rv = 1'b0;
  logic [7:0] m_rd = '0;
  string      last_tag = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_pair u_psw_pair (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_mask(cmd_mask), .cmd_acc(cmd_acc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_acc(rsp_acc),
    .sense_pin(sense_pin), .flag_pin(flag_pin), .alu_we(alu_we),
    .alu_cc(alu_cc), .alu_idc(alu_idc), .alu_ovf(alu_ovf), .alu_cy(alu_cy),
    .stat_hi(stat_hi), .stat_lo(stat_lo)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] test_cc(input logic [7:0] w, input logic [7:0] m);
    return ((w & m) == m) ? 2'b00 : 2'b10;
  endfunction

  task automatic check_state();
    chk("R8 sense live", {7'b0, stat_hi[7]}, {7'b0, sense_pin});
    chk({last_tag, " high word"}, stat_hi, m_hi | {sense_pin, 7'b0});
    chk({last_tag, " low word"}, stat_lo, m_lo);
    chk("R9 flag pin", {7'b0, flag_pin}, {7'b0, m_hi[6]});
    chk("R4 R11 response valid", {7'b0, rsp_valid}, {7'b0, m_rv});
    if (m_rv) chk("R4 response data", rsp_acc, m_rd);
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [7:0] mk,
                      input logic [7:0] ac, input logic rr, input logic aw,
                      input logic [1:0] acc_cc, input logic [2:0] afl, input logic sn);
    logic       a, exp_ready, low_tgt;
    logic [7:0] ih, old_lo;
    @(negedge clk);
    check_state();
    cmd_valid = v; cmd_op = op; cmd_mask = mk; cmd_acc = ac; rsp_ready = rr;
    alu_we = aw; alu_cc = acc_cc; alu_idc = afl[2]; alu_ovf = afl[1]; alu_cy = afl[0];
    sense_pin = sn;
    #1;
    exp_ready = !m_rv || rr;
    chk("R11 ready rule", {7'b0, cmd_ready}, {7'b0, exp_ready});
    a = v && exp_ready;
    ih = m_hi | {sn, 7'b0};
    old_lo = m_lo;
    low_tgt = a && (op == 4'd2 || op == 4'd6 || op == 4'd8 || op == 4'd9 || op == 4'd10);
    last_tag = aw ? "R10 alu update" : "R12 no change";
    if (a) begin
      case (op)
        4'd1:  begin m_hi = ac & HK;              last_tag = "R2 load high"; end
        4'd2:  begin m_lo = ac;                   last_tag = "R3 load low"; end
        4'd5:  begin m_hi = ih & ~mk & HK;        last_tag = "R5 clear high"; end
        4'd6:  begin m_lo = m_lo & ~mk;           last_tag = "R5 clear low"; end
        4'd7:  begin m_hi = (ih | mk) & HK;       last_tag = "R6 set high"; end
        4'd8:  begin m_lo = m_lo | mk;            last_tag = "R6 set low"; end
        4'd9:  begin m_lo[7:6] = test_cc(ih, mk); last_tag = "R7 test high"; end
        4'd10: begin m_lo[7:6] = test_cc(old_lo, mk); last_tag = "R7 test low"; end
        default: ;
      endcase
    end
    if (aw && !low_tgt) begin
      m_lo[7:6] = acc_cc; m_lo[5] = afl[2]; m_lo[2] = afl[1]; m_lo[0] = afl[0];
    end
    if (a && (op == 4'd3 || op == 4'd4)) begin
      m_rv = 1'b1;
      m_rd = (op == 4'd3) ? ih : old_lo;
    end else if (rr) begin
      m_rv = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    chk("R1 reset high", stat_hi, 8'h00);
    chk("R1 reset low", stat_lo, 8'h00);
    chk("R1 reset flag", {7'b0, flag_pin}, 8'h00);
    chk("R1 reset rsp_valid", {7'b0, rsp_valid}, 8'h00);
    rst_n = 1'b1;

    // R2: load high with all ones; bit 7 and bits 4..3 do not stick
    step(1, 4'd1, 8'h00, 8'hFF, 1, 0, 2'b00, 3'b000, 0);
    // R4: store high
    step(1, 4'd3, 8'h00, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    // R8: sense changes, nothing else
    step(0, 4'd0, 8'h00, 8'h00, 1, 0, 2'b00, 3'b000, 1);
    step(1, 4'd3, 8'h00, 8'h00, 1, 0, 2'b00, 3'b000, 1);
    // R3, R5, R6 on the low word
    step(1, 4'd2, 8'h00, 8'h5A, 1, 0, 2'b00, 3'b000, 1);
    step(1, 4'd6, 8'h0F, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd8, 8'h03, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    // R7: all-set, partial, empty mask, high word with zero bits
    step(1, 4'd10, 8'h50, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd10, 8'h0C, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd10, 8'h00, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd9, 8'h18, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd9, 8'h80, 8'h00, 1, 0, 2'b00, 3'b000, 1);
    // R5/R6 on high word, flag clear then set
    step(1, 4'd5, 8'h40, 8'h00, 1, 0, 2'b00, 3'b000, 1);
    step(1, 4'd7, 8'hC0, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    // R11: stall a stored response, offered command is refused
    step(1, 4'd4, 8'h00, 8'h00, 0, 0, 2'b00, 3'b000, 0);
    step(1, 4'd2, 8'h00, 8'hAA, 0, 0, 2'b00, 3'b000, 0);
    step(1, 4'd2, 8'h00, 8'hAA, 0, 0, 2'b00, 3'b000, 0);
    step(0, 4'd0, 8'h00, 8'h00, 1, 0, 2'b00, 3'b000, 0);
    // R10: alu alone, then alu against a low-word load
    step(0, 4'd0, 8'h00, 8'h00, 1, 1, 2'b01, 3'b111, 0);
    step(1, 4'd2, 8'h00, 8'h18, 1, 1, 2'b11, 3'b101, 0);
    step(1, 4'd1, 8'h00, 8'h25, 1, 1, 2'b10, 3'b010, 0);
    // R12: undefined codes and nop
    step(1, 4'd11, 8'hFF, 8'hFF, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd15, 8'hFF, 8'hFF, 1, 0, 2'b00, 3'b000, 0);
    step(1, 4'd0, 8'hFF, 8'hFF, 1, 0, 2'b00, 3'b000, 0);

    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 9) < 8, 4'($urandom_range(0, 12)), 8'($urandom),
           8'($urandom), $urandom_range(0, 9) < 7, $urandom_range(0, 9) < 3,
           2'($urandom), 3'($urandom),
           ($urandom_range(0, 9) < 1) ? ~sense_pin : sense_pin);
    end
    @(negedge clk);
    check_state();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule